// File: doc/BRIEF.md
# Transactional Region Nesting Controller

This block tracks how deeply a processor front end is nested inside hardware transactional regions. Each begin request is checked against a feature-enable input and a lock-prefix flag, and then against a range check on the fallback target. A begin that passes these checks increments a depth counter. The outermost begin latches a fallback program counter, sets an active flag and pulses a checkpoint request. End requests unwind the nesting, and the last one pulses a commit. An abort, whether requested explicitly or caused by a begin that would go past the maximum depth, clears the nesting. It then pulses a discard of buffered memory updates, reports a status code and redirects fetch to the latched fallback address.

The fallback target is the next-instruction address plus a sign-extended displacement. It is masked according to the operating mode. Register checkpointing and memory buffering live elsewhere and are seen here only as single-cycle pulses. All outputs are registered. A request sampled at a rising edge is visible on the outputs directly after that edge.

Top module: `tnc_nest_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the depth, the active flag and the latched fallback address, and drives every pulse output low.
- R2: A begin with the lock prefix set or with the feature enable low raises `ud_fault` for one cycle and leaves the depth, the active flag and the fallback address unchanged.
- R3: A begin outside 64-bit mode raises `gp_fault` for one cycle and changes no state when the low 32 bits of its target exceed 0xFFFF with `real_mode` high, or exceed `cs_limit` with `real_mode` low.
- R4: A begin at depth 0 sets the depth to 1, sets `active`, pulses `ckpt_pulse` and latches the fallback address.
- R5: Mode encodings are 00 for 16-bit, 01 for 32-bit, and 10 or 11 for 64-bit. The latched fallback is the target ANDed with 0xFFFF, with 0xFFFFFFFF, or left unmasked, respectively.
- R6: A begin at a depth between 1 and DEPTH_MAX-1 increments the depth, and leaves the fallback address unchanged with no checkpoint pulse.
- R7: A begin at depth DEPTH_MAX (default 7) performs abort processing with status code 2'b10 instead of incrementing.
- R8: An abort request while the depth is non-zero sets the depth to 0, clears `active`, pulses `discard_pulse` and `redirect_vld`, and gives status code 2'b01. An abort request at depth 0 has no effect. `redirect_pc` always shows the latched fallback address.
- R9: An end at non-zero depth decrements the depth. When the depth reaches 0, `active` clears and `commit_pulse` is raised for one cycle.
- R10: An end at depth 0 raises `end_fault` for one cycle and changes no state.
- R11: When requests coincide, begin faults (R2 before R3) win over an abort, an abort wins over a begin, and a begin wins over an end. The losing requests are dropped.
- R12: The target is `next_pc` plus `disp` sign-extended to the address width, with the sum wrapping modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| begin_req | input | 1 | Request to enter a transactional region |
| end_req | input | 1 | Request to leave one nesting level |
| abort_req | input | 1 | Explicit abort request |
| feat_en | input | 1 | Transactional feature enabled |
| lock_pfx | input | 1 | Begin instruction carries a lock prefix |
| mode | input | 2 | Operating mode: 00 16-bit, 01 32-bit, 1x 64-bit |
| real_mode | input | 1 | Real-address range check instead of segment limit |
| next_pc | input | AW | Address of the instruction after the begin |
| disp | input | DW | Signed displacement to the fallback handler |
| cs_limit | input | 32 | Code segment limit for protected-mode checking |
| depth | output | DEPTH_W | Current nesting depth |
| active | output | 1 | Inside a transactional region |
| fallback_pc | output | AW | Latched fallback address |
| ud_fault | output | 1 | Undefined-opcode fault pulse |
| gp_fault | output | 1 | General-protection fault pulse, error code 0 |
| end_fault | output | 1 | End without an open region |
| ckpt_pulse | output | 1 | Request to checkpoint register state |
| commit_pulse | output | 1 | Request to commit the outermost region |
| discard_pulse | output | 1 | Request to drop buffered memory updates |
| redirect_vld | output | 1 | Fetch redirect pulse |
| redirect_pc | output | AW | Redirect target (latched fallback) |
| status_code | output | 2 | Abort cause: 01 explicit, 10 nest overflow, 00 otherwise |

## Verification
The hardest case to reach from the ports is the overflow abort. It needs DEPTH_MAX consecutive successful begins, and a begin that takes the depth to its maximum must be followed by one more begin before any end or abort request arrives. The directed phase builds this ladder explicitly and checks that the fallback latched on the first rung is the one the redirect reports. A long biased-random phase then drives begins more often than ends, so the depth climbs back to the ceiling many times, interleaved with coincident requests and faulting begins.

// File: rtl/tnc_pkg.sv
package tnc_pkg;

    typedef enum logic [1:0] {
        MODE_16  = 2'b00,
        MODE_32  = 2'b01,
        MODE_64  = 2'b10,
        MODE_64X = 2'b11
    } tnc_mode_e;

    typedef enum logic [1:0] {
        STAT_NONE     = 2'b00,
        STAT_EXPLICIT = 2'b01,
        STAT_OVERFLOW = 2'b10
    } tnc_status_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_UD,
        OP_GP,
        OP_ABORT_REQ,
        OP_ABORT_OVF,
        OP_BEGIN,
        OP_END,
        OP_END_FLT
    } tnc_op_e;

endpackage

// File: rtl/tnc_target.sv
module tnc_target #(
    parameter int AW = 64,
    parameter int DW = 32
) (
    input  logic [AW-1:0] next_pc,
    input  logic [DW-1:0] disp,
    input  logic [1:0]    mode,
    input  logic          real_mode,
    input  logic [31:0]   cs_limit,
    output logic [AW-1:0] target_masked,
    output logic          gp_viol
);
    import tnc_pkg::*;

    localparam int EXT = AW - DW;

    logic [AW-1:0] raw;
    logic [31:0]   low32;

    always_comb begin
        raw   = next_pc + {{EXT{disp[DW-1]}}, disp};
        low32 = raw[31:0];
        case (tnc_mode_e'(mode))
            MODE_16: target_masked = {{(AW-16){1'b0}}, raw[15:0]};
            MODE_32: target_masked = {{(AW-32){1'b0}}, raw[31:0]};
            default: target_masked = raw;
        endcase
        if (mode[1]) begin
            gp_viol = 1'b0;
        end else if (real_mode) begin
            gp_viol = (low32 > 32'h0000_FFFF);
        end else begin
            gp_viol = (low32 > cs_limit);
        end
    end

endmodule

// File: rtl/tnc_op_sel.sv
module tnc_op_sel #(
    parameter int DEPTH_MAX = 7,
    parameter int DEPTH_W   = 3
) (
    input  logic               begin_req,
    input  logic               end_req,
    input  logic               abort_req,
    input  logic               feat_en,
    input  logic               lock_pfx,
    input  logic               gp_viol,
    input  logic [DEPTH_W-1:0] depth,
    output tnc_pkg::tnc_op_e   op
);
    import tnc_pkg::*;

    logic at_zero;
    logic at_max;

    always_comb begin
        at_zero = (depth == '0);
        at_max  = (depth == DEPTH_W'(DEPTH_MAX));
        if (begin_req && (lock_pfx || !feat_en)) begin
            op = OP_UD;
        end else if (begin_req && gp_viol) begin
            op = OP_GP;
        end else if (abort_req && !at_zero) begin
            op = OP_ABORT_REQ;
        end else if (begin_req && at_max) begin
            op = OP_ABORT_OVF;
        end else if (begin_req) begin
            op = OP_BEGIN;
        end else if (end_req && at_zero) begin
            op = OP_END_FLT;
        end else if (end_req) begin
            op = OP_END;
        end else begin
            op = OP_IDLE;
        end
    end

endmodule

// File: rtl/tnc_nest_ctrl.sv
module tnc_nest_ctrl #(
    parameter int AW        = 64,
    parameter int DW        = 32,
    parameter int DEPTH_MAX = 7,
    parameter int DEPTH_W   = $clog2(DEPTH_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               begin_req,
    input  logic               end_req,
    input  logic               abort_req,
    input  logic               feat_en,
    input  logic               lock_pfx,
    input  logic [1:0]         mode,
    input  logic               real_mode,
    input  logic [AW-1:0]      next_pc,
    input  logic [DW-1:0]      disp,
    input  logic [31:0]        cs_limit,
    output logic [DEPTH_W-1:0] depth,
    output logic               active,
    output logic [AW-1:0]      fallback_pc,
    output logic               ud_fault,
    output logic               gp_fault,
    output logic               end_fault,
    output logic               ckpt_pulse,
    output logic               commit_pulse,
    output logic               discard_pulse,
    output logic               redirect_vld,
    output logic [AW-1:0]      redirect_pc,
    output logic [1:0]         status_code
);
    import tnc_pkg::*;

    typedef struct packed {
        logic [DEPTH_W-1:0] depth;
        logic               active;
        logic [AW-1:0]      fallback;
        logic               ud;
        logic               gp;
        logic               efl;
        logic               ckpt;
        logic               commit;
        logic               discard;
        tnc_status_e        status;
    } nest_state_t;

    nest_state_t st_d, st_q;
    tnc_op_e     op;
    logic [AW-1:0] tgt_masked;
    logic          gp_viol;

    tnc_target #(.AW(AW), .DW(DW)) target_i (
        .next_pc       (next_pc),
        .disp          (disp),
        .mode          (mode),
        .real_mode     (real_mode),
        .cs_limit      (cs_limit),
        .target_masked (tgt_masked),
        .gp_viol       (gp_viol)
    );

    tnc_op_sel #(.DEPTH_MAX(DEPTH_MAX), .DEPTH_W(DEPTH_W)) sel_i (
        .begin_req (begin_req),
        .end_req   (end_req),
        .abort_req (abort_req),
        .feat_en   (feat_en),
        .lock_pfx  (lock_pfx),
        .gp_viol   (gp_viol),
        .depth     (st_q.depth),
        .op        (op)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ud      = 1'b0;
        st_d.gp      = 1'b0;
        st_d.efl     = 1'b0;
        st_d.ckpt    = 1'b0;
        st_d.commit  = 1'b0;
        st_d.discard = 1'b0;
        st_d.status  = STAT_NONE;
        case (op)
            OP_UD: st_d.ud = 1'b1;
            OP_GP: st_d.gp = 1'b1;
            OP_ABORT_REQ, OP_ABORT_OVF: begin
                st_d.depth   = '0;
                st_d.active  = 1'b0;
                st_d.discard = 1'b1;
                st_d.status  = (op == OP_ABORT_REQ) ? STAT_EXPLICIT : STAT_OVERFLOW;
            end
            OP_BEGIN: begin
                if (st_q.depth == '0) begin
                    st_d.fallback = tgt_masked;
                    st_d.active   = 1'b1;
                    st_d.ckpt     = 1'b1;
                end
                st_d.depth = st_q.depth + 1'b1;
            end
            OP_END: begin
                st_d.depth = st_q.depth - 1'b1;
                if (st_q.depth == DEPTH_W'(1)) begin
                    st_d.active = 1'b0;
                    st_d.commit = 1'b1;
                end
            end
            OP_END_FLT: st_d.efl = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign depth         = st_q.depth;
    assign active        = st_q.active;
    assign fallback_pc   = st_q.fallback;
    assign ud_fault      = st_q.ud;
    assign gp_fault      = st_q.gp;
    assign end_fault     = st_q.efl;
    assign ckpt_pulse    = st_q.ckpt;
    assign commit_pulse  = st_q.commit;
    assign discard_pulse = st_q.discard;
    assign redirect_vld  = st_q.discard;
    assign redirect_pc   = st_q.fallback;
    assign status_code   = st_q.status;

endmodule

// File: rtl/tnc_nest_ctrl_chk.sv
module tnc_nest_ctrl_chk #(
    parameter int AW        = 64,
    parameter int DEPTH_MAX = 7,
    parameter int DEPTH_W   = $clog2(DEPTH_MAX + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [DEPTH_W-1:0] depth,
    input logic               active,
    input logic [AW-1:0]      fallback_pc,
    input logic               ud_fault,
    input logic               gp_fault,
    input logic               end_fault,
    input logic               ckpt_pulse,
    input logic               commit_pulse,
    input logic               discard_pulse,
    input logic [1:0]         status_code
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    // R9
    active_tracks_depth_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (active == (depth != '0)));

    // R7
    depth_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (depth <= DEPTH_W'(DEPTH_MAX)));

    // R2
    ud_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && ud_fault) |-> (depth == $past(depth) && fallback_pc == $past(fallback_pc)));

    // R3
    gp_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && gp_fault) |-> (depth == $past(depth) && fallback_pc == $past(fallback_pc)));

    // R4
    ckpt_outermost_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && ckpt_pulse) |-> (depth == DEPTH_W'(1) && $past(depth) == '0));

    // R8
    discard_from_active_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && discard_pulse) |-> ($past(active) && depth == '0 && status_code != 2'b00));

    // R9
    commit_last_level_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && commit_pulse) |-> ($past(depth) == DEPTH_W'(1) && !active));

    // R11
    single_event_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ud_fault, gp_fault, end_fault, ckpt_pulse, commit_pulse, discard_pulse}));

endmodule

bind tnc_nest_ctrl tnc_nest_ctrl_chk #(
    .AW(AW),
    .DEPTH_MAX(DEPTH_MAX),
    .DEPTH_W(DEPTH_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .depth         (depth),
    .active        (active),
    .fallback_pc   (fallback_pc),
    .ud_fault      (ud_fault),
    .gp_fault      (gp_fault),
    .end_fault     (end_fault),
    .ckpt_pulse    (ckpt_pulse),
    .commit_pulse  (commit_pulse),
    .discard_pulse (discard_pulse),
    .status_code   (status_code)
);

// File: tb/tnc_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module tnc_nest_ctrl_tb_top;
    localparam int AW = 64;
    localparam int DW = 32;
    localparam int DMAX = 7;
    localparam int DWID = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic begin_req = 0, end_req = 0, abort_req = 0, feat_en = 0, lock_pfx = 0;
    logic [1:0] mode = 2'b10;
    logic real_mode = 0;
    logic [AW-1:0] next_pc = '0;
    logic [DW-1:0] disp = '0;
    logic [31:0] cs_limit = '0;
    logic [DWID-1:0] depth;
    logic active, ud_fault, gp_fault, end_fault, ckpt_pulse, commit_pulse, discard_pulse, redirect_vld;
    logic [AW-1:0] fallback_pc, redirect_pc;
    logic [1:0] status_code;

    always #2.5 clk = ~clk;

    tnc_nest_ctrl #(.AW(AW), .DW(DW), .DEPTH_MAX(DMAX)) dut_i (
        .clk(clk), .rst(rst), .begin_req(begin_req), .end_req(end_req), .abort_req(abort_req),
        .feat_en(feat_en), .lock_pfx(lock_pfx), .mode(mode), .real_mode(real_mode),
        .next_pc(next_pc), .disp(disp), .cs_limit(cs_limit), .depth(depth), .active(active),
        .fallback_pc(fallback_pc), .ud_fault(ud_fault), .gp_fault(gp_fault), .end_fault(end_fault),
        .ckpt_pulse(ckpt_pulse), .commit_pulse(commit_pulse), .discard_pulse(discard_pulse),
        .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .status_code(status_code)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int m_depth = 0;
    bit m_active = 0;
    longint unsigned m_fb = 0;
    bit m_ud, m_gp, m_efl, m_ckpt, m_commit, m_discard;
    int m_status = 0;

    task automatic cmp(string tag, string nm, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, nm, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        cmp(tag, "depth", longint'(depth), longint'(m_depth));
        cmp(tag, "active", longint'(active), longint'(m_active));
        cmp(tag, "fallback_pc", fallback_pc, m_fb);
        cmp(tag, "redirect_pc", redirect_pc, m_fb);
        cmp(tag, "ud_fault", longint'(ud_fault), longint'(m_ud));
        cmp(tag, "gp_fault", longint'(gp_fault), longint'(m_gp));
        cmp(tag, "end_fault", longint'(end_fault), longint'(m_efl));
        cmp(tag, "ckpt_pulse", longint'(ckpt_pulse), longint'(m_ckpt));
        cmp(tag, "commit_pulse", longint'(commit_pulse), longint'(m_commit));
        cmp(tag, "discard_pulse", longint'(discard_pulse), longint'(m_discard));
        cmp(tag, "redirect_vld", longint'(redirect_vld), longint'(m_discard));
        cmp(tag, "status_code", longint'(status_code), longint'(m_status));
    endtask

    // behavioural next-state of the reference model (R2..R12)
    task automatic model(bit b, bit e, bit a, bit fe, bit lk, bit [1:0] md, bit rm,
                         longint unsigned npc, int dsp, int unsigned lim);
        longint unsigned tgt, fb, lo;
        bit gp;
        tgt = npc + longint'(dsp);                        // R12
        if (md == 2'b00)      fb = tgt & 64'hFFFF;        // R5
        else if (md == 2'b01) fb = tgt & 64'hFFFF_FFFF;
        else                  fb = tgt;
        lo = tgt & 64'hFFFF_FFFF;
        gp = (md < 2) && (rm ? (lo > 64'hFFFF) : (lo > longint'(lim)));
        m_ud = 0; m_gp = 0; m_efl = 0; m_ckpt = 0; m_commit = 0; m_discard = 0; m_status = 0;
        if (b && (lk || !fe)) m_ud = 1;
        else if (b && gp) m_gp = 1;
        else if (a && m_depth > 0) begin
            m_discard = 1; m_status = 1; m_depth = 0; m_active = 0;
        end else if (b && m_depth == DMAX) begin
            m_discard = 1; m_status = 2; m_depth = 0; m_active = 0;
        end else if (b) begin
            if (m_depth == 0) begin m_fb = fb; m_ckpt = 1; m_active = 1; end
            m_depth++;
        end else if (e) begin
            if (m_depth == 0) m_efl = 1;
            else begin
                m_depth--;
                if (m_depth == 0) begin m_active = 0; m_commit = 1; end
            end
        end
    endtask

    task automatic step(string tag, bit b, bit e, bit a, bit fe, bit lk, bit [1:0] md, bit rm,
                        longint unsigned npc, int dsp, int unsigned lim);
        begin_req = b; end_req = e; abort_req = a; feat_en = fe; lock_pfx = lk;
        mode = md; real_mode = rm; next_pc = npc; disp = dsp; cs_limit = lim;
        model(b, e, a, fe, lk, md, rm, npc, dsp, lim);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 1, 0, 2'b10, 0, 64'h0, 0, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        compare_all("R1");
        idle("R1");
        // R2: lock prefix and feature disabled
        step("R2", 1, 0, 0, 1, 1, 2'b10, 0, 64'h1000, 16, 32'hFFFF_FFFF);
        step("R2", 1, 0, 0, 0, 0, 2'b10, 0, 64'h1000, 16, 32'hFFFF_FFFF);
        // R10: end at depth 0
        step("R10", 0, 1, 0, 1, 0, 2'b10, 0, 0, 0, 0);
        // R8: abort while idle has no effect
        step("R8", 0, 0, 1, 1, 0, 2'b10, 0, 0, 0, 0);
        // R4 R12: outermost begin in 64-bit mode, negative displacement
        step("R4", 1, 0, 0, 1, 0, 2'b10, 0, 64'hABCD_0000_0000_1000, -32, 32'h0);
        // R6: inner begin keeps fallback
        step("R6", 1, 0, 0, 1, 0, 2'b10, 0, 64'h5555_0000, 8, 32'h0);
        // R11: begin and end together, begin wins
        step("R11", 1, 1, 0, 1, 0, 2'b10, 0, 64'h7000, 8, 32'h0);
        // R9: unwind to zero
        step("R9", 0, 1, 0, 1, 0, 2'b10, 0, 0, 0, 0);
        step("R9", 0, 1, 0, 1, 0, 2'b10, 0, 0, 0, 0);
        step("R9", 0, 1, 0, 1, 0, 2'b10, 0, 0, 0, 0);
        // R5: 16-bit mode protected, big limit, target masked
        step("R5", 1, 0, 0, 1, 0, 2'b00, 0, 64'h0001_2300, 32'h45, 32'hFFFF_FFFF);
        step("R9", 0, 1, 0, 1, 0, 2'b00, 0, 0, 0, 0);
        // R5: 32-bit mode with upper address bits set
        step("R5", 1, 0, 0, 1, 0, 2'b01, 0, 64'h00AB_8000_1000, 4, 32'hFFFF_FFFF);
        step("R9", 0, 1, 0, 1, 0, 2'b01, 0, 0, 0, 0);
        // R3: real-address range and segment limit
        step("R3", 1, 0, 0, 1, 0, 2'b00, 1, 64'hFFF0, 32'h20, 32'hFFFF_FFFF);
        step("R3", 1, 0, 0, 1, 0, 2'b01, 0, 64'h2000, 32'h10, 32'h2000);
        step("R3", 1, 0, 0, 1, 0, 2'b00, 1, 64'hFF00, 32'h10, 32'h0);
        step("R9", 0, 1, 0, 1, 0, 2'b10, 0, 0, 0, 0);
        // R7: climb to the ceiling and one more
        for (int i = 0; i < DMAX; i++)
            step("R7", 1, 0, 0, 1, 0, 2'b10, 0, 64'h9000 + 64'(i), 100, 0);
        step("R7", 1, 0, 0, 1, 0, 2'b10, 0, 64'h1, 1, 0);
        idle("R7");
        // R8: explicit abort at depth 2, and R11 abort beats begin
        step("R8", 1, 0, 0, 1, 0, 2'b10, 0, 64'h4000, 0, 0);
        step("R8", 1, 0, 0, 1, 0, 2'b10, 0, 64'h4100, 0, 0);
        step("R11", 1, 0, 1, 1, 0, 2'b10, 0, 64'h4200, 0, 0);
        // R11: begin fault beats abort
        step("R4", 1, 0, 0, 1, 0, 2'b10, 0, 64'h6000, 0, 0);
        step("R11", 1, 0, 1, 1, 1, 2'b10, 0, 64'h6100, 0, 0);
        step("R11", 1, 1, 1, 1, 0, 2'b01, 0, 64'h6100, 0, 32'h10);
        step("R8", 0, 0, 1, 1, 0, 2'b10, 0, 0, 0, 0);
        // R11: random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            bit b, e, a, lk, fe, rm;
            r = $urandom;
            b  = (r % 100) < 45;
            e  = ((r >> 8) % 100) < 35;
            a  = ((r >> 16) % 100) < 4;
            lk = ((r >> 24) % 100) < 4;
            fe = ($urandom % 100) < 96;
            rm = ($urandom % 100) < 20;
            step("R11", b, e, a, fe, lk, 2'($urandom), rm,
                 {32'($urandom), 32'($urandom % 32'h3_0000)}, int'($urandom % 8192) - 4096,
                 (($urandom % 4) == 0) ? 32'h0001_0000 : 32'hFFFF_FFFF);
        end
        rst = 1;
        m_depth = 0; m_active = 0; m_fb = 0;
        m_ud = 0; m_gp = 0; m_efl = 0; m_ckpt = 0; m_commit = 0; m_discard = 0; m_status = 0;
        @(negedge clk);
        compare_all("R1");
        rst = 0;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule